// File: doc/BRIEF.md
# Escaped-byte link codec

This block sits between a byte-wide serial receiver/transmitter pair and a consumer that stores each data byte and answers with a readback byte. The host reserves one character, 0x20, as an escape marker. Any byte it cannot send directly goes out as the marker followed by the value with bit 7 set. The codec removes the marker and clears bit 7 of the byte that follows before handing it to the consumer. It returns the marker to the host at once. When the consumer's reply goes back out, the codec sets bit 7 again, so the host sees its own escaped form echoed.

A single escape-pending flag links the two directions. A marker sets it. The next data byte is decoded under it. The transmission of that byte's reply clears it. Only one data byte is in flight at a time, and received bytes that arrive while one is outstanding are discarded. Marker echoes wait in a small saturating counter and leave before any queued reply. A byte only goes out in the cycle after the transmitter reports that it is ready.

Top module: `ttyesc_codec`

## Requirements
- R1: After reset, dec_valid and tx_valid are low and the escape flag is clear, so the first data byte is decoded unchanged.
- R2: An accepted received byte equal to 0x20 is never presented on dec_valid/dec_data.
- R3: Each accepted 0x20 queues one echo of 0x20 on the transmit side. Up to 15 echoes can be pending, and markers beyond that are dropped.
- R4: An accepted 0x20 sets the escape flag. The next accepted non-0x20 byte is decoded with bit 7 forced to 0 (0xC1 gives 0x41, 0xA0 gives 0x20).
- R5: A reply transmitted while the flag is set has bit 7 forced to 1 (0x41 is sent as 0xC1). The flag is then clear, so the next data byte is decoded unchanged.
- R6: With the flag clear, a received data byte is decoded unchanged and its reply is transmitted unchanged.
- R7: tx_valid is a one-cycle strobe that is high only in the cycle after tx_ready was sampled high. One byte goes out per item queued.
- R8: When an echo and a reply are both waiting, all pending echoes are transmitted before the reply.
- R9: Between issuing a decoded byte and transmitting its reply, received bytes (markers included) are ignored, with no decode, no echo and no flag change. A rep_valid pulse with no byte outstanding is ignored and produces no transmission.
- R10: dec_valid rises in the cycle after the rx_valid cycle of an accepted data byte, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| dec_valid | output | 1 | Decoded byte strobe to consumer |
| dec_data | output | 8 | Decoded byte |
| rep_valid | input | 1 | Consumer reply strobe |
| rep_data | input | 8 | Consumer reply byte |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Byte to transmit |

## Verification
The hardest case to reach is a reply that is ready while several marker echoes are still queued. It only happens when the transmitter stalls across a whole escaped exchange. The bench holds tx_ready low, sends three markers and an escaped byte, supplies the reply, and then releases tx_ready to check the output order and the restored bit 7. A random phase follows. It drives bursts of markers, stray replies and a toggling tx_ready, and a behavioural model compares both outputs on every clock.

// File: rtl/ttyesc_pkg.sv
package ttyesc_pkg;
  typedef enum logic [1:0] {
    TX_NONE  = 2'd0,
    TX_ECHO  = 2'd1,
    TX_REPLY = 2'd2
  } tx_src_e;
endpackage

// File: rtl/ttyesc_echo_cnt.sv
module ttyesc_echo_cnt #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  output logic pending,
  output logic full
);
  logic [CNT_W-1:0] count;

  assign pending = |count;
  assign full    = &count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (push && !pop) begin
      count <= count + 1'b1;
    end else if (pop && !push) begin
      count <= count - 1'b1;
    end
  end

  // R3
  echo_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && full) |-> 1'b0);
endmodule

// File: rtl/ttyesc_rx_path.sv
module ttyesc_rx_path #(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] MARK = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              busy,
  input  logic              flag,
  input  logic              echo_full,
  output logic              mark_seen,
  output logic              take_data,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data
);
  localparam logic [DATA_W-1:0] LOW_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic accept;
  logic is_mark;

  assign accept    = rx_valid && !busy;
  assign is_mark   = (rx_data == MARK);
  assign mark_seen = accept && is_mark && !echo_full;
  assign take_data = accept && !is_mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      dec_data  <= '0;
    end else begin
      dec_valid <= take_data;
      if (take_data) begin
        dec_data <= flag ? (rx_data & LOW_MASK) : rx_data;
      end
    end
  end

  // R2
  no_marker_pass_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> ($past(rx_data) != MARK));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !$past(busy));
endmodule

// File: rtl/ttyesc_tx_arb.sv
module ttyesc_tx_arb
  import ttyesc_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter logic [DATA_W-1:0] MARK = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rep_valid,
  input  logic [DATA_W-1:0] rep_data,
  input  logic              busy,
  input  logic              flag,
  input  logic              tx_ready,
  input  logic              echo_pending,
  output logic              echo_pop,
  output logic              reply_sent,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  localparam logic [DATA_W-1:0] HIGH_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic              rep_held;
  logic [DATA_W-1:0] rep_q;
  tx_src_e           src;

  always_comb begin
    src = TX_NONE;
    if (tx_ready) begin
      if (echo_pending)  src = TX_ECHO;
      else if (rep_held) src = TX_REPLY;
    end
  end

  assign echo_pop   = (src == TX_ECHO);
  assign reply_sent = (src == TX_REPLY);

  always_ff @(posedge clk) begin
    if (rst) begin
      rep_held <= 1'b0;
      rep_q    <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (reply_sent) begin
        rep_held <= 1'b0;
      end else if (rep_valid && busy && !rep_held) begin
        rep_held <= 1'b1;
        rep_q    <= rep_data;
      end
      tx_valid <= (src != TX_NONE);
      case (src)
        TX_ECHO:  tx_data <= MARK;
        TX_REPLY: tx_data <= flag ? (rep_q | HIGH_BIT) : rep_q;
        default:  tx_data <= tx_data;
      endcase
    end
  end

  // R7
  tx_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(tx_ready));

  // R8
  echo_first_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && echo_pending) |=> (tx_valid && tx_data == MARK));
endmodule

// File: rtl/ttyesc_codec.sv
module ttyesc_codec #(
  parameter int              DATA_W     = 8,
  parameter int              ECHO_CNT_W = 4,
  parameter logic [DATA_W-1:0] MARK     = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data,
  input  logic              rep_valid,
  input  logic [DATA_W-1:0] rep_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  logic flag;
  logic busy;
  logic mark_seen;
  logic take_data;
  logic echo_full;
  logic echo_pending;
  logic echo_pop;
  logic reply_sent;

  ttyesc_rx_path #(.DATA_W(DATA_W), .MARK(MARK)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .busy      (busy),
    .flag      (flag),
    .echo_full (echo_full),
    .mark_seen (mark_seen),
    .take_data (take_data),
    .dec_valid (dec_valid),
    .dec_data  (dec_data)
  );

  ttyesc_echo_cnt #(.CNT_W(ECHO_CNT_W)) u_echo (
    .clk     (clk),
    .rst     (rst),
    .push    (mark_seen),
    .pop     (echo_pop),
    .pending (echo_pending),
    .full    (echo_full)
  );

  ttyesc_tx_arb #(.DATA_W(DATA_W), .MARK(MARK)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .rep_valid    (rep_valid),
    .rep_data     (rep_data),
    .busy         (busy),
    .flag         (flag),
    .tx_ready     (tx_ready),
    .echo_pending (echo_pending),
    .echo_pop     (echo_pop),
    .reply_sent   (reply_sent),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      busy <= 1'b0;
    end else begin
      if (mark_seen)       flag <= 1'b1;
      else if (reply_sent) flag <= 1'b0;
      if (take_data)       busy <= 1'b1;
      else if (reply_sent) busy <= 1'b0;
    end
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    mark_seen |=> flag);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    reply_sent |=> !flag);
endmodule

// File: tb/ttyesc_codec_test.sv
module ttyesc_codec_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rep_valid = 1'b0;
  logic [7:0] rep_data = 8'h00;
  logic       tx_ready = 1'b0;
  logic       dec_valid;
  logic [7:0] dec_data;
  logic       tx_valid;
  logic [7:0] tx_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [7:0] tx_log[$];
  logic [7:0] dec_log[$];

  // behavioural model state
  bit         m_busy, m_flag, m_rep_h, m_dec_v, m_tx_v;
  int         m_echo;
  logic [7:0] m_rep, m_dec_d, m_tx_d;

  always #10 clk = ~clk;

  ttyesc_codec uut (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .dec_valid(dec_valid), .dec_data(dec_data),
    .rep_valid(rep_valid), .rep_data(rep_data),
    .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit acc, mk, dat, take_rep, pop, sent;
    if (rst) begin
      m_busy = 0; m_flag = 0; m_rep_h = 0; m_dec_v = 0; m_tx_v = 0;
      m_echo = 0; m_rep = 0; m_dec_d = 0; m_tx_d = 0;
    end else begin
      acc = rx_valid && !m_busy;
      mk  = acc && rx_data == 8'h20 && m_echo < 15;
      dat = acc && rx_data != 8'h20;
      take_rep = rep_valid && m_busy && !m_rep_h;
      pop = 0; sent = 0; m_tx_v = 0;
      if (tx_ready && m_echo > 0) begin
        m_tx_v = 1; m_tx_d = 8'h20; pop = 1;
      end else if (tx_ready && m_rep_h) begin
        m_tx_v = 1; m_tx_d = m_flag ? (m_rep | 8'h80) : m_rep; sent = 1;
      end
      m_dec_v = dat;
      if (dat) m_dec_d = m_flag ? (rx_data & 8'h7f) : rx_data;
      m_echo = m_echo + (mk ? 1 : 0) - (pop ? 1 : 0);
      if (mk) m_flag = 1; else if (sent) m_flag = 0;
      if (dat) m_busy = 1; else if (sent) m_busy = 0;
      if (sent) m_rep_h = 0;
      else if (take_rep) begin m_rep_h = 1; m_rep = rep_data; end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(dec_valid == m_dec_v && (!dec_valid || dec_data == m_dec_d),
          "R4 model dec", {dec_valid, dec_data}, {m_dec_v, m_dec_d});
      chk(tx_valid == m_tx_v && (!tx_valid || tx_data == m_tx_d),
          "R7 model tx", {tx_valid, tx_data}, {m_tx_v, m_tx_d});
      if (tx_valid)  tx_log.push_back(tx_data);
      if (dec_valid) dec_log.push_back(dec_data);
    end
    if (cycles > 200000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic rep(input logic [7:0] b);
    @(negedge clk); rep_valid = 1; rep_data = b;
    @(negedge clk); rep_valid = 0;
  endtask

  task automatic clr();
    tx_log.delete(); dec_log.delete();
  endtask

  initial begin
    tick(3);
    chk(dec_valid == 0 && tx_valid == 0, "R1 reset outputs", {dec_valid, tx_valid}, 0);
    @(negedge clk); rst = 0;
    tx_ready = 1;

    // R6 / R10 / R1: plain byte
    clr();
    rx(8'h41);
    chk(dec_valid == 1, "R10 dec latency", dec_valid, 1);
    chk(dec_data == 8'h41, "R1 first byte unchanged", dec_data, 8'h41);
    tick(1);
    chk(dec_valid == 0, "R10 one cycle strobe", dec_valid, 0);
    rep(8'h41); tick(3);
    chk(tx_log.size() == 1 && tx_log[0] == 8'h41, "R6 reply unchanged",
        tx_log.size() ? tx_log[0] : -1, 8'h41);
    chk(tx_log.size() == 1, "R7 single strobe", tx_log.size(), 1);

    // R2 R3 R4 R5
    clr();
    rx(8'h20); tick(3);
    chk(dec_log.size() == 0, "R2 marker not decoded", dec_log.size(), 0);
    chk(tx_log.size() == 1 && tx_log[0] == 8'h20, "R3 marker echoed",
        tx_log.size() ? tx_log[0] : -1, 8'h20);
    rx(8'hC1); tick(2);
    chk(dec_log.size() == 1 && dec_log[0] == 8'h41, "R4 bit7 cleared",
        dec_log.size() ? dec_log[0] : -1, 8'h41);
    rep(8'h41); tick(3);
    chk(tx_log.size() == 2 && tx_log[1] == 8'hC1, "R5 bit7 restored",
        tx_log.size() > 1 ? tx_log[1] : -1, 8'hC1);
    clr();
    rx(8'hC1); tick(2);
    chk(dec_log.size() == 1 && dec_log[0] == 8'hC1, "R5 flag cleared",
        dec_log.size() ? dec_log[0] : -1, 8'hC1);
    rep(8'h99); tick(3);
    chk(tx_log.size() == 1 && tx_log[0] == 8'h99, "R6 reply no flag",
        tx_log.size() ? tx_log[0] : -1, 8'h99);

    // R4: escaped marker value
    clr();
    rx(8'h20); rx(8'hA0); tick(2);
    chk(dec_log.size() == 1 && dec_log[0] == 8'h20, "R4 escaped 0xA0",
        dec_log.size() ? dec_log[0] : -1, 8'h20);
    rep(8'h20); tick(3);
    chk(tx_log.size() == 2 && tx_log[1] == 8'hA0, "R5 echo of 0x20 reply",
        tx_log.size() > 1 ? tx_log[1] : -1, 8'hA0);

    // R9: busy ignore
    clr();
    rx(8'h33); rx(8'h20); rx(8'h44); tick(2);
    chk(dec_log.size() == 1, "R9 bytes ignored while busy", dec_log.size(), 1);
    chk(tx_log.size() == 0, "R9 no echo while busy", tx_log.size(), 0);
    rep(8'h33); tick(3);
    chk(tx_log.size() == 1 && tx_log[0] == 8'h33, "R9 flag untouched",
        tx_log.size() ? tx_log[0] : -1, 8'h33);
    clr();
    rep(8'h55); tick(3);
    chk(tx_log.size() == 0, "R9 stray reply ignored", tx_log.size(), 0);
    rx(8'h66); tick(2);
    rep(8'h66); tick(3);
    chk(dec_log.size() == 1 && tx_log.size() == 1 && tx_log[0] == 8'h66,
        "R9 stray reply not stored", tx_log.size() ? tx_log[0] : -1, 8'h66);

    // R8 / R7: stalled transmitter
    clr();
    tx_ready = 0;
    rx(8'h20); rx(8'h20); rx(8'h20); rx(8'h85); tick(2);
    rep(8'h05); tick(3);
    chk(tx_log.size() == 0, "R7 no tx without ready", tx_log.size(), 0);
    chk(dec_log.size() == 1 && dec_log[0] == 8'h05, "R4 after marker run",
        dec_log.size() ? dec_log[0] : -1, 8'h05);
    @(negedge clk); tx_ready = 1;
    tick(8);
    chk(tx_log.size() == 4, "R8 count", tx_log.size(), 4);
    if (tx_log.size() == 4) begin
      chk(tx_log[0] == 8'h20 && tx_log[1] == 8'h20 && tx_log[2] == 8'h20,
          "R8 echoes first", tx_log[2], 8'h20);
      chk(tx_log[3] == 8'h85, "R8 reply last", tx_log[3], 8'h85);
    end

    // random phase, compared against model every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rx_valid  = ($urandom_range(0, 2) == 0);
      rx_data   = ($urandom_range(0, 2) == 0) ? 8'h20 : 8'($urandom);
      rep_valid = ($urandom_range(0, 3) == 0);
      rep_data  = 8'($urandom);
      tx_ready  = ($urandom_range(0, 3) != 0);
    end
    @(negedge clk);
    rx_valid = 0; rep_valid = 0; tx_ready = 1;
    tick(40);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule